// File: doc/BRIEF.md
# Selectable-Ratio Third-Order Sinc Decimator

This block turns the single-bit output stream of a sigma-delta modulator into unsigned 16-bit samples. It has three integrators that run on every clock and three differencing stages that run once per output period. The result is the moving average of the bit density over three cascaded windows. One bitstream bit is taken per clock edge. A 3-bit select sets the decimation ratio to a power of two between 32 and 512. Each result comes with a one-cycle valid pulse and a settled flag.

At every ratio the full-precision result is cut down to a 16-bit code. A bit density of one half gives mid-scale, and a stream of all ones saturates at the top code. A downstream controller can therefore read the same code range at any ratio. The settled flag marks the first outputs after reset or after a ratio change, because the difference stages still hold history from before that event.

Top module: `sinc3_decimator`

## Requirements
- R1: While reset is held, and until the first valid pulse after reset, `sample`, `sample_valid` and `sample_settled` are all 0.
- R2: Select code c in 0..4 gives a decimation ratio DR = 32·2^c. Consecutive valid pulses are then exactly DR clock cycles apart. The reset default is code 3 (DR = 256).
- R3: Select codes 5, 6 and 7 all mean DR = 256. Moving the select between two codes that give the same ratio changes nothing: pulse spacing continues unbroken and the settled flag stays high.
- R4: `sample_valid` is high for one cycle per output. `sample_settled` is only high together with `sample_valid`.
- R5: A change of select that gives a different ratio restarts the output period. Any output already in flight at that edge is dropped. The first three outputs after reset or after such a change have `sample_settled` = 0, and every later output has it at 1.
- R6: An input with ones-density exactly 1/2 (pattern 1010...) settles to code 32768 at every ratio.
- R7: The full-precision result has 3·log2(DR) bits, and its 16 most significant bits form the code. For DR = 32 (15 bits) the result is shifted left by one. A density of 57/64 gives 58368 for DR ≥ 64, and a density of 127/128 gives 65024 for DR ≥ 128.
- R8: An all-ones input settles to 65535 (saturated). An all-zeros input settles to 0.
- R9: A bit value of 1 counts as one and 0 counts as zero. For a periodic input whose period divides DR, the settled code is min(65536·ones/period, 65535).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; one bitstream bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Modulator bitstream |
| ratio_sel | input | 3 | Decimation ratio code (0..4 give 32..512; 5..7 give 256) |
| sample | output | 16 | Unsigned filtered result |
| sample_valid | output | 1 | One-cycle strobe per decimated output |
| sample_settled | output | 1 | High with a valid strobe once the filter history is clean |

## Verification
The bench targets the scaling edge at each end of the ratio range. At DR = 32 a missing left shift would halve every code. At DR = 512 a result one bit wider than the shift assumes would wrap a full-scale input to 0 instead of saturating at 65535. Ratio changes are tested in both directions. A design that failed to restart its period would give a wrong pulse spacing. One that skipped the settle count would flag stale outputs as settled. One that treated an alias code as a real change would drop its settled flag when nothing had changed. Random periodic patterns check the density-to-code mapping at random ratios, where an inverted input or an off-by-one difference stage would show up as a wrong code.

// File: rtl/sinc3_pkg.sv
// Shared constants and types for the sinc3 decimator.
// Assumes ratios are consecutive powers of two starting at 2**MIN_LOG2.
package sinc3_pkg;
    localparam int ORDER      = 3;
    localparam int MIN_LOG2   = 5;
    localparam int MAX_LOG2   = 9;
    localparam int NUM_RATIOS = MAX_LOG2 - MIN_LOG2 + 1;
    localparam int OUT_W      = 16;
    localparam int CODE_W     = 3;
    localparam int DEF_CODE   = 3;
    localparam int SETTLE_N   = 3;
    // One extra bit so that a full-scale sum (DR**3) is still representable.
    localparam int ACC_W      = ORDER * MAX_LOG2 + 1;
    localparam int CNT_W      = MAX_LOG2;

    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/sinc3_rate_ctrl.sv
// Ratio decode and decimation phase counter.
// Legalizes the select code, restarts the period when the ratio changes,
// and emits a dump pulse on the last cycle of every output period.
module sinc3_rate_ctrl
    import sinc3_pkg::*;
#(
    parameter int MIN_LG = MIN_LOG2,
    parameter int NUM_R  = NUM_RATIOS,
    parameter int DEF_C  = DEF_CODE,
    parameter int CW     = CODE_W,
    parameter int NW     = CNT_W
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] ratio_sel,
    output logic [CW-1:0] code_q,
    output logic          restart,
    output logic          dump
);
    logic [CW-1:0] sel_ok;
    logic [NW-1:0] cnt_q;
    logic [NW-1:0] last_cnt;

    // Map unused codes onto the default ratio.
    always_comb sel_ok = (ratio_sel < CW'(NUM_R)) ? ratio_sel : CW'(DEF_C);

    // Last phase value is DR-1, a run of ones shortened for small ratios.
    always_comb last_cnt = {NW{1'b1}} >> (CW'(NUM_R - 1) - code_q);

    always_comb restart = (sel_ok != code_q);
    always_comb dump    = !restart && (cnt_q == last_cnt);

    // Hold the active ratio and advance the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CW'(DEF_C);
            cnt_q  <= '0;
        end else if (restart) begin
            code_q <= sel_ok;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= dump ? '0 : cnt_q + 1'b1;
        end
    end

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_cnt);
endmodule

// File: rtl/sinc3_integrators.sv
// Cascade of ORDER integrators clocked at the modulator rate.
// Uses wrap-around arithmetic; the differencing stages undo the wrap.
module sinc3_integrators
    import sinc3_pkg::*;
#(
    parameter int N  = ORDER,
    parameter int AW = ACC_W
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_in,
    output logic [AW-1:0] integ_out
);
    for (genvar k = 0; k < N; k++) begin : g_int
        logic [AW-1:0] acc;
        logic [AW-1:0] feed;
        if (k == 0) begin : g_first
            assign feed = AW'(bit_in);
            // R9
            step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                AW'(acc - $past(acc)) <= AW'(1));
        end else begin : g_next
            assign feed = g_int[k-1].acc;
        end
        // Accumulate the previous stage every clock.
        always_ff @(posedge clk) begin
            if (!rst_n) acc <= '0;
            else        acc <= acc + feed;
        end
    end

    assign integ_out = g_int[N-1].acc;
endmodule

// File: rtl/sinc3_combs.sv
// Cascade of ORDER differencing stages evaluated on each dump pulse.
// Assumes dump arrives once per decimation period.
module sinc3_combs
    import sinc3_pkg::*;
#(
    parameter int N  = ORDER,
    parameter int AW = ACC_W
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dump,
    input  logic [AW-1:0] integ_in,
    output logic [AW-1:0] full_q,
    output logic          full_vld
);
    for (genvar k = 0; k < N; k++) begin : g_cmb
        logic [AW-1:0] src;
        logic [AW-1:0] dl;
        logic [AW-1:0] df;
        if (k == 0) begin : g_first
            assign src = integ_in;
        end else begin : g_next
            assign src = g_cmb[k-1].df;
        end
        assign df = src - dl;
        // Remember this stage's input for the next period.
        always_ff @(posedge clk) begin
            if (!rst_n)    dl <= '0;
            else if (dump) dl <= src;
        end
    end

    // Capture the final difference and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q   <= '0;
            full_vld <= 1'b0;
        end else begin
            full_vld <= dump;
            if (dump) full_q <= g_cmb[N-1].df;
        end
    end
endmodule

// File: rtl/sinc3_scaler.sv
// Reduces the full-precision result to OUT_W bits for the active ratio.
// Widths below OUT_W are shifted up; values of 2**W or more saturate.
module sinc3_scaler
    import sinc3_pkg::*;
#(
    parameter int N      = ORDER,
    parameter int MIN_LG = MIN_LOG2,
    parameter int NUM_R  = NUM_RATIOS,
    parameter int AW     = ACC_W,
    parameter int OW     = OUT_W,
    parameter int CW     = CODE_W
)(
    input  logic [AW-1:0] full,
    input  logic [CW-1:0] code,
    output logic [OW-1:0] scaled
);
    logic [NUM_R-1:0][OW-1:0] cand;

    for (genvar c = 0; c < NUM_R; c++) begin : g_scl
        localparam int W = N * (MIN_LG + c);
        logic [OW-1:0] trunc;
        if (W >= OW) begin : g_down
            assign trunc = OW'(full >> (W - OW));
        end else begin : g_up
            assign trunc = OW'(full << (OW - W));
        end
        assign cand[c] = (full >= (AW'(1) << W)) ? {OW{1'b1}} : trunc;
    end

    // Pick the candidate for the active ratio.
    always_comb scaled = cand[code];
endmodule

// File: rtl/sinc3_decimator.sv
// Top level: sinc3 decimator with runtime-selectable power-of-two ratio.
// Assumes one bitstream bit per clock; outputs are registered.
module sinc3_decimator
    import sinc3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic [CODE_W-1:0] ratio_sel,
    output logic [OUT_W-1:0]  sample,
    output logic              sample_valid,
    output logic              sample_settled
);
    localparam int SW = $clog2(SETTLE_N + 1);

    logic [CODE_W-1:0] code_q;
    logic              restart;
    logic              dump;
    acc_t              integ;
    acc_t              full;
    logic              full_vld;
    logic [OUT_W-1:0]  scaled;
    logic [SW-1:0]     settle_q;

    sinc3_rate_ctrl u_rate (
        .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel),
        .code_q(code_q), .restart(restart), .dump(dump)
    );

    sinc3_integrators u_int (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .integ_out(integ)
    );

    sinc3_combs u_cmb (
        .clk(clk), .rst_n(rst_n), .dump(dump), .integ_in(integ),
        .full_q(full), .full_vld(full_vld)
    );

    sinc3_scaler u_scl (
        .full(full), .code(code_q), .scaled(scaled)
    );

    // Register the output word, strobes and the settle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample         <= '0;
            sample_valid   <= 1'b0;
            sample_settled <= 1'b0;
            settle_q       <= '0;
        end else if (restart) begin
            sample_valid   <= 1'b0;
            sample_settled <= 1'b0;
            settle_q       <= '0;
        end else if (full_vld) begin
            sample         <= scaled;
            sample_valid   <= 1'b1;
            sample_settled <= (settle_q == SW'(SETTLE_N));
            if (settle_q != SW'(SETTLE_N)) settle_q <= settle_q + 1'b1;
        end else begin
            sample_valid   <= 1'b0;
            sample_settled <= 1'b0;
        end
    end

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R4
    settled_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_settled |-> sample_valid);

    // R5
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sample_valid);
endmodule

// File: tb/sinc3_decimator_test.sv
// Self-checking bench: directed corners plus seeded random density patterns.
module sinc3_decimator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic [2:0]  ratio_sel = 3'd3;
    logic [15:0] sample;
    logic        sample_valid;
    logic        sample_settled;

    logic [127:0] pat = {64{2'b01}};
    int           plen = 2;
    int           pidx = 0;
    int           n_chk = 0;
    int           n_fail = 0;

    always #5 clk = ~clk;

    sinc3_decimator uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .ratio_sel(ratio_sel),
        .sample(sample), .sample_valid(sample_valid), .sample_settled(sample_settled)
    );

    // Bitstream driver: repeat the current pattern forever.
    initial forever begin
        @(negedge clk);
        bit_in = pat[pidx % plen];
        pidx = (pidx + 1) % plen;
    end

    function automatic int ratio_of(input int code);
        return (code <= 4) ? (32 << code) : 256;
    endfunction

    function automatic int exp_code(input int ones, input int period);
        int v;
        v = (ones * 65536) / period;
        return (v > 65535) ? 65535 : v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_pattern(input int ones, input int period);
        pat  = {128{1'b1}} >> (128 - ones);
        plen = period;
    endtask

    task automatic next_strobe(output logic [15:0] s, output logic f, output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!sample_valid);
        s = sample;
        f = sample_settled;
    endtask

    task automatic set_ratio(input int code);
        @(negedge clk);
        ratio_sel = 3'(code);
        @(negedge clk);
    endtask

    // Skip n strobes, then return the next one.
    task automatic settle_read(input int n, output logic [15:0] s, output logic f, output int gap);
        for (int i = 0; i < n; i++) next_strobe(s, f, gap);
        next_strobe(s, f, gap);
    endtask

    initial begin
        #(180000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] s;
        logic        f;
        int          g;
        logic [3:0]  flags;
        int          codes [5] = '{0, 1, 2, 4, 3};

        void'($urandom(32'd20417));
        repeat (5) @(negedge clk);
        // R1: outputs idle in reset
        check(sample == 0 && !sample_valid && !sample_settled, "R1 reset", int'(sample), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(sample == 0 && !sample_valid && !sample_settled, "R1 after reset", int'(sample), 0);

        // R2, R5, R6: every ratio with half density
        foreach (codes[i]) begin
            set_pattern(1, 2);
            set_ratio(codes[i]);
            for (int k = 0; k < 4; k++) begin
                next_strobe(s, f, g);
                flags[k] = f;
            end
            check(flags == 4'b1000, "R5 settle flags", int'(flags), 8);
            next_strobe(s, f, g);
            check(g == ratio_of(codes[i]), "R2 spacing", g, ratio_of(codes[i]));
            check(s == 16'd32768, "R6 midscale", int'(s), 32768);
        end

        // R7: 57/64 density for DR >= 64
        for (int c = 1; c <= 4; c++) begin
            set_ratio(c);
            set_pattern(57, 64);
            settle_read(4, s, f, g);
            check(s == 16'd58368, "R7 57/64", int'(s), 58368);
        end

        // R7: 127/128 density for DR >= 128
        for (int c = 2; c <= 4; c++) begin
            set_ratio(c);
            set_pattern(127, 128);
            settle_read(4, s, f, g);
            check(s == 16'd65024, "R7 127/128", int'(s), 65024);
        end

        // R8: saturation and zero at both ends of the range
        set_ratio(0);
        set_pattern(2, 2);
        settle_read(4, s, f, g);
        check(s == 16'hFFFF, "R8 ones DR32", int'(s), 65535);
        set_pattern(0, 2);
        settle_read(4, s, f, g);
        check(s == 16'd0, "R8 zeros DR32", int'(s), 0);
        set_ratio(4);
        set_pattern(2, 2);
        settle_read(4, s, f, g);
        check(s == 16'hFFFF, "R8 ones DR512", int'(s), 65535);
        set_pattern(0, 2);
        settle_read(4, s, f, g);
        check(s == 16'd0, "R8 zeros DR512", int'(s), 0);
        set_pattern(1, 2);
        check(f == 1'b1, "R5 settled steady", int'(f), 1);

        // R3: alias code 7 for the active 256 ratio has no effect
        set_ratio(3);
        settle_read(4, s, f, g);
        set_ratio(7);
        next_strobe(s, f, g);
        check(f == 1'b1 && g <= 256, "R3 alias keeps settled", int'(f), 1);
        next_strobe(s, f, g);
        check(g == 256 && f == 1'b1, "R3 alias spacing", g, 256);
        check(s == 16'd32768, "R3 alias data", int'(s), 32768);

        // R3, R5: code 6 from DR=32 restarts to 256
        set_ratio(0);
        settle_read(1, s, f, g);
        set_ratio(6);
        for (int k = 0; k < 4; k++) begin
            next_strobe(s, f, g);
            flags[k] = f;
        end
        check(flags == 4'b1000, "R5 restart via alias", int'(flags), 8);
        next_strobe(s, f, g);
        check(g == 256, "R3 code6 spacing", g, 256);

        // R9: random periodic patterns at random ratios
        for (int t = 0; t < 12; t++) begin
            int c;
            int ones;
            c    = int'($urandom_range(4, 0));
            ones = int'($urandom_range(32, 0));
            set_ratio(c);
            set_pattern(ones, 32);
            settle_read(4, s, f, g);
            check(s == 16'(exp_code(ones, 32)), "R9 random density", int'(s), exp_code(ones, 32));
            check(f == 1'b1 && g == ratio_of(c), "R2 random spacing", g, ratio_of(c));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule